// File: doc/BRIEF.md
# Debug Interface Lock Register

This block holds a single lock bit that stands between software and a debug subsystem interface. Software takes the lock by reading it. The read is granted, returns 1 and sets the lock, only if no debug request was seen at any point of that read access. If either request was seen, the read returns 0, the lock stays free, and software tries again. A write forces the lock: writing 1 takes it regardless of the debug side, and writing 0 frees it. A mask bit lets software leave the force-active request out of the check. The system power-up request is never masked. A status register shows both request inputs live.

Accesses use a simple register bus. The host raises `bus_sel` with the address, direction and write bit, and holds them. The access lasts `ACC_CYCLES` clock cycles. In the last of them `bus_done` is high, read data is valid, and the effect of the access is applied at the clock edge that closes that cycle. The lock state is driven on `lock_held` to the guarded interface.

Top module: `dbg_if_lock`

## Requirements
- R1: A read of the lock register (address 0) while the lock is free returns 1 in bit 0 and takes the lock, when neither request counted in any cycle of that access.
- R2: A read of the lock register while the lock is free returns 0 and leaves the lock free, if a counted request was high in any cycle of the access, first and last cycle included. Requests outside the access have no effect.
- R3: Writing 1 (bus_wdata) to the lock register takes the lock whatever the request inputs are doing.
- R4: Writing 0 to the lock register releases the lock.
- R5: The mask register (address 1, bit 0, resets to 0, reads back) set to 1 makes the force-active request uncounted in the lock check.
- R6: The power-up request is always counted, whatever the mask.
- R7: A read of the lock register while the lock is held returns 1 and the lock stays held.
- R8: The status register (address 2) returns the live force-active request in bit 0 and the power-up request in bit 1, sampled in the last access cycle. Writes to it change no state.
- R9: After reset the lock is free, `lock_held` is low and the mask is 0.
- R10: Every access lasts ACC_CYCLES cycles. `bus_done` is high only in its last cycle, and the lock changes only at the edge that closes an access to the lock register.
- R11: Address 3 reads 0, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access in progress; held by the host until bus_done |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 lock, 1 mask, 2 status, 3 unused |
| bus_wdata | input | 1 | Write bit |
| bus_rdata | output | 2 | Read data, valid while bus_done is high on a read |
| bus_done | output | 1 | High in the last cycle of an access |
| dbg_force_req | input | 1 | Debug force-active request |
| dbg_pwrup_req | input | 1 | Debug system power-up request |
| lock_held | output | 1 | Lock state to the guarded interface |

## Verification
The bench places a single request pulse in the first, a middle and the last cycle of a lock read. A design that only samples requests at one end of the access would wrongly grant one of these. It also places requests in the cycles just before and after a read, which must not block it. Combining the mask with each request separates a design that masks the power-up request, or ignores the mask, from a correct one. Held-lock reads under active requests, forced writes during requests, and writes to the status and unused addresses expose designs that drop a held lock or decode writes too widely.

// File: rtl/dbg_if_lock_pkg.sv
package dbg_if_lock_pkg;

  typedef enum logic [1:0] {
    ADR_LOCK = 2'd0,
    ADR_MASK = 2'd1,
    ADR_STAT = 2'd2,
    ADR_NONE = 2'd3
  } reg_addr_e;

  // A request counts against the lock check in this cycle.
  function automatic logic req_counts(input logic force_req, input logic pwrup_req,
                                      input logic mask_force);
    return pwrup_req | (force_req & ~mask_force);
  endfunction

  // Value a lock read returns; the lock holds that value afterwards.
  function automatic logic read_grants(input logic held, input logic blocked);
    return held | ~blocked;
  endfunction

endpackage

// File: rtl/dbg_if_lock_access.sv
module dbg_if_lock_access #(
  parameter int ACC_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  output logic first,
  output logic last
);
  localparam int CW = (ACC_CYCLES > 1) ? $clog2(ACC_CYCLES) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(ACC_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign first = sel && (cnt_q == '0);
  assign last  = sel && (cnt_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!sel || last) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_IDX); // R10
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/dbg_if_lock_tracker.sv
module dbg_if_lock_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic first,
  input  logic last,
  input  logic cond,
  input  logic pwrup_req,
  output logic blocked
);
  logic seen_q;
  logic carry;

  assign carry   = first ? 1'b0 : seen_q;
  assign blocked = carry | cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            seen_q <= 1'b0;
    else if (!sel || last) seen_q <= 1'b0;
    else                   seen_q <= blocked;
  end

  AST_PWR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && pwrup_req) |-> blocked); // R6
  AST_SEEN_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && blocked && !last) |=> (sel -> blocked)); // R2
endmodule

// File: rtl/dbg_if_lock_core.sv
module dbg_if_lock_core
  import dbg_if_lock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_lock,
  input  logic wr_lock,
  input  logic wr_mask,
  input  logic wbit,
  input  logic blocked,
  output logic lock_q,
  output logic mask_q,
  output logic rd_grant
);
  logic lock_nxt;

  assign rd_grant = read_grants(lock_q, blocked);

  always_comb begin
    lock_nxt = lock_q;
    if (wr_lock)      lock_nxt = wbit;
    else if (rd_lock) lock_nxt = rd_grant;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      lock_q <= lock_nxt;
      if (wr_mask) mask_q <= wbit;
    end
  end

  AST_GRANT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lock && !lock_q && !blocked) |=> lock_q); // R1
  AST_DENY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lock && !lock_q && blocked) |=> !lock_q); // R2
  AST_FORCE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && wbit) |=> lock_q); // R3
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && !wbit) |=> !lock_q); // R4
  AST_HELD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lock && lock_q) |=> lock_q); // R7
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_lock && !wr_lock) |=> $stable(lock_q)); // R10
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q)); // R5
endmodule

// File: rtl/dbg_if_lock.sv
module dbg_if_lock
  import dbg_if_lock_pkg::*;
#(
  parameter int ACC_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic       bus_wdata,
  output logic [1:0] bus_rdata,
  output logic       bus_done,
  input  logic       dbg_force_req,
  input  logic       dbg_pwrup_req,
  output logic       lock_held
);
  reg_addr_e addr;
  logic first, last, cond, blocked;
  logic rd_lock, wr_lock, wr_mask;
  logic lock_q, mask_q, rd_grant;

  assign addr = reg_addr_e'(bus_addr);

  dbg_if_lock_access #(.ACC_CYCLES(ACC_CYCLES)) u_access (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .first(first), .last(last)
  );

  assign cond = req_counts(dbg_force_req, dbg_pwrup_req, mask_q);

  dbg_if_lock_tracker u_track (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .first(first), .last(last),
    .cond(cond), .pwrup_req(dbg_pwrup_req), .blocked(blocked)
  );

  assign rd_lock = last && !bus_wr && (addr == ADR_LOCK);
  assign wr_lock = last &&  bus_wr && (addr == ADR_LOCK);
  assign wr_mask = last &&  bus_wr && (addr == ADR_MASK);

  dbg_if_lock_core u_core (
    .clk(clk), .rst_n(rst_n), .rd_lock(rd_lock), .wr_lock(wr_lock),
    .wr_mask(wr_mask), .wbit(bus_wdata), .blocked(blocked),
    .lock_q(lock_q), .mask_q(mask_q), .rd_grant(rd_grant)
  );

  always_comb begin
    bus_rdata = '0;
    if (last && !bus_wr) begin
      unique case (addr)
        ADR_LOCK: bus_rdata = {1'b0, rd_grant};
        ADR_MASK: bus_rdata = {1'b0, mask_q};
        ADR_STAT: bus_rdata = {dbg_pwrup_req, dbg_force_req};
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign bus_done  = last;
  assign lock_held = lock_q;

  AST_DONE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done |-> bus_sel); // R10
  AST_HELD_READ_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_done && !bus_wr && addr == ADR_LOCK && lock_held) |-> bus_rdata[0]); // R7
  AST_READ_MATCHES_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_done && !bus_wr && addr == ADR_LOCK) |=> (lock_held == $past(bus_rdata[0]))); // R1
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_done && !bus_wr && addr == ADR_NONE) |-> (bus_rdata == 2'b00)); // R11
endmodule

// File: tb/sim_dbg_if_lock.sv
module sim_dbg_if_lock;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, bus_wdata = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [1:0] bus_rdata;
  logic bus_done, lock_held;
  logic dbg_force_req = 1'b0, dbg_pwrup_req = 1'b0;

  int checks = 0;
  int fails = 0;
  bit m_lock = 1'b0;
  bit m_mask = 1'b0;

  always #2.5 clk = ~clk;

  dbg_if_lock #(.ACC_CYCLES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_done(bus_done), .dbg_force_req(dbg_force_req),
    .dbg_pwrup_req(dbg_pwrup_req), .lock_held(lock_held)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected read result computed from the requirement text.
  function automatic int exp_read(input logic [1:0] a, input logic [7:0] fp,
                                  input logic [7:0] pp);
    bit hit = 1'b0;
    for (int k = 0; k < N; k++)
      if (pp[k] || (fp[k] && !m_mask)) hit = 1'b1;
    case (a)
      2'd0: return (m_lock || !hit) ? 1 : 0;
      2'd1: return int'(m_mask);
      2'd2: return int'({pp[N-1], fp[N-1]});
      default: return 0;
    endcase
  endfunction

  task automatic access(input string req, input bit wr, input logic [1:0] a,
                        input bit wb, input logic [7:0] fp, input logic [7:0] pp,
                        input bit after_req);
    int exp;
    exp = exp_read(a, fp, pp);
    for (int k = 0; k < N; k++) begin
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = wb;
      dbg_force_req = fp[k]; dbg_pwrup_req = pp[k];
      @(negedge clk);
      if (k < N - 1) begin
        if (bus_done) check("R10 early done", 1, 0);
      end else begin
        check("R10 done in last cycle", int'(bus_done), 1);
        if (!wr) check(req, int'(bus_rdata), exp);
      end
    end
    if (wr) begin
      if (a == 2'd0) m_lock = wb;
      else if (a == 2'd1) m_mask = wb;
    end else if (a == 2'd0) m_lock = (exp != 0);
    @(posedge clk); #1;
    bus_sel = 1'b0;
    dbg_force_req = after_req; dbg_pwrup_req = after_req;
    @(negedge clk);
    check({req, " lock after"}, int'(lock_held), int'(m_lock));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d0c5eed));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R9 lock_held after reset", int'(lock_held), 0);
    check("R9 done idle after reset", int'(bus_done), 0);
    access("R9 mask reads 0 after reset", 0, 2'd1, 0, 8'h00, 8'h00, 1);
    access("R8 status live", 0, 2'd2, 0, 8'h04, 8'h00, 0);
    access("R8 status live pwr", 0, 2'd2, 0, 8'h00, 8'h04, 0);
    access("R2 force in first cycle", 0, 2'd0, 0, 8'h01, 8'h00, 0);
    access("R2 force in middle cycle", 0, 2'd0, 0, 8'h02, 8'h00, 0);
    access("R2 pwrup in last cycle", 0, 2'd0, 0, 8'h00, 8'h04, 0);
    access("R1 quiet read grants", 0, 2'd0, 0, 8'h00, 8'h00, 1);
    access("R7 held read under requests", 0, 2'd0, 0, 8'h07, 8'h07, 0);
    access("R4 write 0 releases", 1, 2'd0, 0, 8'h07, 8'h00, 1);
    access("R2 requests outside window ignored", 0, 2'd0, 0, 8'h00, 8'h00, 0);
    access("R4 release again", 1, 2'd0, 0, 8'h00, 8'h00, 0);
    access("R3 write 1 under requests", 1, 2'd0, 1, 8'h07, 8'h07, 0);
    access("R4 release", 1, 2'd0, 0, 8'h00, 8'h00, 0);
    access("R5 mask set", 1, 2'd1, 1, 8'h00, 8'h00, 0);
    access("R5 mask reads back", 0, 2'd1, 0, 8'h00, 8'h00, 0);
    access("R5 masked force grants", 0, 2'd0, 0, 8'h07, 8'h00, 0);
    access("R4 release", 1, 2'd0, 0, 8'h00, 8'h00, 0);
    access("R6 pwrup blocks with mask", 0, 2'd0, 0, 8'h00, 8'h02, 0);
    access("R8 write to status ignored", 1, 2'd2, 1, 8'h00, 8'h00, 0);
    access("R11 write to unused ignored", 1, 2'd3, 0, 8'h00, 8'h00, 0);
    access("R11 mask unchanged", 0, 2'd1, 0, 8'h00, 8'h00, 0);
    access("R11 unused reads 0", 0, 2'd3, 0, 8'h07, 8'h07, 0);
    access("R5 mask clear", 1, 2'd1, 0, 8'h00, 8'h00, 0);
    for (int i = 0; i < 400; i++) begin
      logic [7:0] fp, pp;
      logic [1:0] a;
      bit wr;
      fp = 8'($urandom & $urandom & $urandom);
      pp = 8'($urandom & $urandom & $urandom & $urandom);
      a  = ($urandom_range(0, 3) < 2) ? 2'd0 : 2'($urandom);
      wr = ($urandom_range(0, 4) == 0);
      access("R1 R2 random access", wr, a, 1'($urandom), fp, pp, 1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule